// File: doc/BRIEF.md
# Bunch-Crossing Command Word Generator

This block produces one 44-bit timing-and-fast-control command word on every bunch-crossing clock. Readout boards downstream use the word to stay synchronous with the machine and to learn what to do with each crossing. The word carries the current crossing number, a 16-bit event destination, the trigger and calibration type codes, and eight command flags: trigger, crossing veto, full (non-zero-suppressed) readout, header-only, and four reset commands.

Each crossing, the block decides whether to issue a trigger. The gating works in a fixed order. A crossing marked in a loadable filling-scheme pattern is vetoed outright, and so is any crossing inside the follow-on window of a full readout. A raised throttle then turns every accept into a reject. A calibration request then takes over from the low-level trigger sources. When no calibration request is present, the highest-numbered active trigger source wins. After a full-readout crossing, a programmable number of following crossings are vetoed so that the front ends can drain the complete event.

Top module: `tfc_cmd_gen`

## Requirements
- R1: While reset is held, the output word is all zeros. The crossing counter restarts at 0, so the first word after reset carries crossing ID 0. The full-readout window and the filling pattern are also cleared.
- R2: The word has the following layout. Bits 43..32 hold the crossing ID and bits 31..16 the destination. Bits 15..12 hold the trigger type and bits 11..8 the calibration type. Bit 7 is trigger, bit 6 crossing veto, bit 5 full readout, bit 4 header-only, bit 3 back-end reset, bit 2 front-end reset, bit 1 event-ID reset and bit 0 crossing-ID reset. The crossing ID rises by one per word and wraps from NUM_BX-1 (3563) to 0.
- R3: A crossing-ID reset command yields a word with bit 0 set and crossing ID 0, and the next word carries ID 1. The event-ID, front-end and back-end reset commands each set their own bit in the word for the same crossing.
- R4: When the filling-pattern bit for the current crossing ID is 1, the word has veto (bit 6) and header-only (bit 4) set, with trigger 0 and both type fields 0. This holds whatever the trigger, calibration and full-readout requests are.
- R5: While throttle is high, the word has trigger 0 and full readout 0, whether or not trigger or calibration requests are present.
- R6: A calibration request on a crossing that is neither vetoed nor throttled issues a trigger with trigger type 15. The calibration type field then equals the requested type, and the low-level trigger requests are ignored.
- R7: Without calibration, when one or more low-level trigger sources i (0..NSRC-1) are active, a trigger is issued with trigger type i+1 of the highest active i. When no trigger is issued, both type fields are 0.
- R8: Every word reflects the inputs sampled at the clock edge that produces it, so each decision appears exactly one clock after it is presented.
- R9: A full-readout request on a crossing that is neither vetoed nor throttled sets bit 5. The next L crossings then have veto and header-only set, where L is the configured length 1..15 and 0 acts as 1. Requests made inside that window are ignored.
- R10: A pattern write sets or clears the bit for its address, and the change takes effect from the next crossing. Writes to addresses of NUM_BX or above change nothing.
- R11: The destination input appears unchanged in bits 31..16 of the word for the same crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| llt_req | input | NSRC | Low-level trigger source requests |
| throttle | input | 1 | Back-pressure; blocks triggers and full readout |
| cal_req | input | 1 | Calibration trigger request |
| cal_type | input | 4 | Requested calibration type |
| nzs_req | input | 1 | Full-readout request |
| cfg_nzs_len | input | LEN_W | Follow-on veto length after full readout |
| dest | input | 16 | Event destination for this crossing |
| bid_rst_cmd | input | 1 | Crossing-ID reset command |
| eid_rst_cmd | input | 1 | Event-ID reset command |
| fe_rst_cmd | input | 1 | Front-end reset command |
| be_rst_cmd | input | 1 | Back-end reset command |
| pat_wr_en | input | 1 | Filling-pattern write strobe |
| pat_wr_addr | input | 12 | Filling-pattern write address |
| pat_wr_bit | input | 1 | Filling-pattern write value |
| word_out | output | 44 | Registered command word |

## Verification
A wrong crossing counter shows up as a wrong ID in the very next word. It also shifts every pattern veto by the same offset, and that becomes visible once the bench walks through a full orbit. A stale or miscounted follow-on window shows up one crossing after a full-readout word as a veto too many or too few. A dropped pattern write stays hidden until the counter reaches that address, so the bench revisits the written addresses on purpose. Every word is compared against a behavioural model on every clock, so a wrong gating order or a wrong priority is seen in the very crossing that triggers it.

// File: rtl/tfccmd_pkg.sv
package tfccmd_pkg;

    localparam int BXID_W = 12;
    localparam int DEST_W = 16;
    localparam int TT_W   = 4;
    localparam int CT_W   = 4;
    localparam int WORD_W = BXID_W + DEST_W + TT_W + CT_W + 8;

    typedef struct packed {
        logic [BXID_W-1:0] bxid;
        logic [DEST_W-1:0] dest;
        logic [TT_W-1:0]   ttype;
        logic [CT_W-1:0]   ctype;
        logic              trig;
        logic              bx_veto;
        logic              nzs;
        logic              hdr_only;
        logic              be_rst;
        logic              fe_rst;
        logic              eid_rst;
        logic              bid_rst;
    } tfc_word_t;

    function automatic logic [BXID_W-1:0] bx_next(input logic [BXID_W-1:0] cur,
                                                  input logic [BXID_W-1:0] last);
        return (cur == last) ? '0 : cur + BXID_W'(1);
    endfunction

endpackage

// File: rtl/tfc_bx_counter.sv
module tfc_bx_counter import tfccmd_pkg::*; #(
    parameter int NUM_BX = 3564
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    output logic [BXID_W-1:0] bx_cur
);
    localparam logic [BXID_W-1:0] LAST = BXID_W'(NUM_BX - 1);

    logic [BXID_W-1:0] cnt_q;

    assign bx_cur = clr ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= bx_next(bx_cur, LAST);
    end

    assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/tfc_fill_mask.sv
module tfc_fill_mask import tfccmd_pkg::*; #(
    parameter int NUM_BX = 3564
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BXID_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic [BXID_W-1:0] rd_addr,
    output logic              veto
);
    localparam logic [BXID_W-1:0] LAST = BXID_W'(NUM_BX - 1);

    logic [NUM_BX-1:0] mask_q;

    assign veto = (rd_addr <= LAST) ? mask_q[rd_addr] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr_en && (wr_addr <= LAST))
            mask_q[wr_addr] <= wr_bit;
    end

endmodule

// File: rtl/tfc_trig_arbiter.sv
module tfc_trig_arbiter import tfccmd_pkg::*; #(
    parameter int              NSRC      = 4,
    parameter int              LEN_W     = 4,
    parameter logic [TT_W-1:0] CAL_TTYPE = 4'hF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_veto,
    input  logic             throttle,
    input  logic             cal_req,
    input  logic [CT_W-1:0]  cal_type,
    input  logic [NSRC-1:0]  llt_req,
    input  logic             nzs_req,
    input  logic [LEN_W-1:0] nzs_len,
    output logic             trig,
    output logic [TT_W-1:0]  ttype,
    output logic [CT_W-1:0]  ctype,
    output logic             veto,
    output logic             nzs_out
);
    logic [LEN_W-1:0] rem_q;
    logic [TT_W-1:0]  src_code;
    logic             window;

    always_comb begin
        src_code = '0;
        for (int i = 0; i < NSRC; i++)
            if (llt_req[i]) src_code = TT_W'(i + 1);
    end

    assign window  = (rem_q != '0);
    assign veto    = fill_veto | window;
    assign nzs_out = nzs_req & ~veto & ~throttle;

    always_comb begin
        trig  = 1'b0;
        ttype = '0;
        ctype = '0;
        if (!veto && !throttle) begin
            if (cal_req) begin
                trig  = 1'b1;
                ttype = CAL_TTYPE;
                ctype = cal_type;
            end else if (src_code != '0) begin
                trig  = 1'b1;
                ttype = src_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rem_q <= '0;
        else if (nzs_out)
            rem_q <= (nzs_len == '0) ? LEN_W'(1) : nzs_len;
        else if (window)
            rem_q <= rem_q - LEN_W'(1);
    end

    always_comb begin
        if (!rst) begin
            assert_throttle_block_R5: assert (!(throttle && (trig || nzs_out)));
        end
    end

    assert_nzs_window_R9: assert property (@(posedge clk) disable iff (rst)
        nzs_out |=> veto);

endmodule

// File: rtl/tfc_cmd_gen.sv
module tfc_cmd_gen import tfccmd_pkg::*; #(
    parameter int NUM_BX = 3564,
    parameter int NSRC   = 4,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   llt_req,
    input  logic              throttle,
    input  logic              cal_req,
    input  logic [CT_W-1:0]   cal_type,
    input  logic              nzs_req,
    input  logic [LEN_W-1:0]  cfg_nzs_len,
    input  logic [DEST_W-1:0] dest,
    input  logic              bid_rst_cmd,
    input  logic              eid_rst_cmd,
    input  logic              fe_rst_cmd,
    input  logic              be_rst_cmd,
    input  logic              pat_wr_en,
    input  logic [BXID_W-1:0] pat_wr_addr,
    input  logic              pat_wr_bit,
    output logic [WORD_W-1:0] word_out
);
    localparam logic [BXID_W-1:0] LAST = BXID_W'(NUM_BX - 1);

    logic [BXID_W-1:0] bx_cur;
    logic              fill_veto;
    logic              trig, veto, nzs_hit;
    logic [TT_W-1:0]   ttype;
    logic [CT_W-1:0]   ctype;
    tfc_word_t         word_d, word_q;
    logic              started, primed;

    tfc_bx_counter #(.NUM_BX(NUM_BX)) u_cnt (
        .clk(clk), .rst(rst), .clr(bid_rst_cmd), .bx_cur(bx_cur)
    );

    tfc_fill_mask #(.NUM_BX(NUM_BX)) u_mask (
        .clk(clk), .rst(rst), .wr_en(pat_wr_en), .wr_addr(pat_wr_addr),
        .wr_bit(pat_wr_bit), .rd_addr(bx_cur), .veto(fill_veto)
    );

    tfc_trig_arbiter #(.NSRC(NSRC), .LEN_W(LEN_W)) u_arb (
        .clk(clk), .rst(rst), .fill_veto(fill_veto), .throttle(throttle),
        .cal_req(cal_req), .cal_type(cal_type), .llt_req(llt_req),
        .nzs_req(nzs_req), .nzs_len(cfg_nzs_len), .trig(trig),
        .ttype(ttype), .ctype(ctype), .veto(veto), .nzs_out(nzs_hit)
    );

    always_comb begin
        word_d          = '0;
        word_d.bxid     = bx_cur;
        word_d.dest     = dest;
        word_d.ttype    = ttype;
        word_d.ctype    = ctype;
        word_d.trig     = trig;
        word_d.bx_veto  = veto;
        word_d.nzs      = nzs_hit;
        word_d.hdr_only = veto;
        word_d.be_rst   = be_rst_cmd;
        word_d.fe_rst   = fe_rst_cmd;
        word_d.eid_rst  = eid_rst_cmd;
        word_d.bid_rst  = bid_rst_cmd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            started <= 1'b0;
            primed  <= 1'b0;
        end else begin
            word_q  <= word_d;
            started <= 1'b1;
            primed  <= started;
        end
    end

    assign word_out = word_q;

    assert_bxid_step_R2: assert property (@(posedge clk) disable iff (rst || !primed)
        !word_q.bid_rst |-> word_q.bxid == bx_next($past(word_q.bxid), LAST));

    assert_bid_reset_R3: assert property (@(posedge clk) disable iff (rst || !started)
        $past(bid_rst_cmd) |-> (word_q.bid_rst && word_q.bxid == '0));

    assert_veto_header_R4: assert property (@(posedge clk) disable iff (rst)
        word_q.bx_veto |-> (word_q.hdr_only && !word_q.trig));

    assert_idle_types_R7: assert property (@(posedge clk) disable iff (rst)
        !word_q.trig |-> (word_q.ttype == '0 && word_q.ctype == '0));

endmodule

// File: tb/sim_tfc_cmd_gen.sv
`timescale 1ns/1ps
module sim_tfc_cmd_gen;
    localparam int NBX = 3564;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  llt_req = '0;
    logic        throttle = 1'b0, cal_req = 1'b0, nzs_req = 1'b0;
    logic [3:0]  cal_type = '0, cfg_nzs_len = 4'd3;
    logic [15:0] dest = '0;
    logic        bid_rst_cmd = 1'b0, eid_rst_cmd = 1'b0, fe_rst_cmd = 1'b0, be_rst_cmd = 1'b0;
    logic        pat_wr_en = 1'b0, pat_wr_bit = 1'b0;
    logic [11:0] pat_wr_addr = '0;
    logic [43:0] word_out;

    int checks = 0, fails = 0;
    bit finished = 0;

    int m_bx = 0, m_rem = 0;
    bit m_mask [NBX];
    logic [43:0] expw;
    logic [15:0] lfsr = 16'hACE1;

    tfc_cmd_gen u0 (
        .clk(clk), .rst(rst), .llt_req(llt_req), .throttle(throttle),
        .cal_req(cal_req), .cal_type(cal_type), .nzs_req(nzs_req),
        .cfg_nzs_len(cfg_nzs_len), .dest(dest), .bid_rst_cmd(bid_rst_cmd),
        .eid_rst_cmd(eid_rst_cmd), .fe_rst_cmd(fe_rst_cmd), .be_rst_cmd(be_rst_cmd),
        .pat_wr_en(pat_wr_en), .pat_wr_addr(pat_wr_addr), .pat_wr_bit(pat_wr_bit),
        .word_out(word_out)
    );

    always #2.5 clk = ~clk;

    // behavioural model: evaluates the inputs present at this edge
    task automatic model_eval();
        int eff, tt, ct, hi;
        bit veto, trg, nz;
        eff  = bid_rst_cmd ? 0 : m_bx;
        veto = m_mask[eff] || (m_rem > 0);
        nz   = nzs_req && !veto && !throttle;
        trg = 0; tt = 0; ct = 0;
        if (!veto && !throttle) begin
            if (cal_req) begin
                trg = 1; tt = 15; ct = int'(cal_type);
            end else if (llt_req != 0) begin
                hi = 0;
                for (int i = 0; i < 4; i++) if (llt_req[i]) hi = i + 1;
                trg = 1; tt = hi;
            end
        end
        expw = {12'(eff), dest, 4'(tt), 4'(ct), trg, veto, nz, veto,
                be_rst_cmd, fe_rst_cmd, eid_rst_cmd, bid_rst_cmd};
        m_bx = (eff == NBX - 1) ? 0 : eff + 1;
        if (nz) m_rem = (cfg_nzs_len == 0) ? 1 : int'(cfg_nzs_len);
        else if (m_rem > 0) m_rem--;
        if (pat_wr_en && int'(pat_wr_addr) < NBX) m_mask[pat_wr_addr] = pat_wr_bit;
    endtask

    task automatic check(input string tag, input logic [43:0] got, input logic [43:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_eval();
        @(negedge clk);
        check(tag, word_out, expw);
    endtask

    task automatic clear_pulses();
        cal_req = 0; nzs_req = 0; bid_rst_cmd = 0; eid_rst_cmd = 0;
        fe_rst_cmd = 0; be_rst_cmd = 0; pat_wr_en = 0;
    endtask

    initial begin
        for (int i = 0; i < NBX; i++) m_mask[i] = 0;
        repeat (3) @(negedge clk);
        check("R1 reset word", word_out, '0);
        rst = 0;

        // R1 / R11: first words after reset, destination pass-through
        for (int i = 0; i < 6; i++) begin
            dest = 16'h1000 + 16'(i * 257);
            step(i == 0 ? "R1" : "R11");
        end

        // R7: priority among trigger sources
        llt_req = 4'b0001; step("R7");
        llt_req = 4'b0010; step("R7");
        llt_req = 4'b0101; step("R7");
        llt_req = 4'b1111; step("R7");
        llt_req = 4'b0000; step("R7");

        // R6: calibration overrides low-level requests
        llt_req = 4'b1111; cal_req = 1; cal_type = 4'd6; step("R6");
        cal_req = 0; step("R6");

        // R5: throttle blocks triggers, calibration and full readout
        throttle = 1; cal_req = 1; step("R5");
        nzs_req = 1; step("R5");
        clear_pulses(); step("R5");
        throttle = 0; step("R5");
        llt_req = 0;

        // R3: reset commands
        eid_rst_cmd = 1; fe_rst_cmd = 1; step("R3");
        clear_pulses(); be_rst_cmd = 1; step("R3");
        clear_pulses(); bid_rst_cmd = 1; step("R3");
        clear_pulses(); step("R3");
        step("R3");

        // R9: full readout follow-on window, lengths 3, 0 and 15
        cfg_nzs_len = 4'd3; nzs_req = 1; llt_req = 4'b0100; step("R9");
        for (int i = 0; i < 5; i++) step("R9");
        nzs_req = 0; step("R9");
        cfg_nzs_len = 4'd0; nzs_req = 1; step("R9");
        nzs_req = 0; step("R9"); step("R9");
        cfg_nzs_len = 4'd15; nzs_req = 1; step("R9");
        nzs_req = 0;
        for (int i = 0; i < 17; i++) step("R9");
        llt_req = 0;

        // R10: pattern writes, in range and out of range
        pat_wr_en = 1; pat_wr_addr = 12'd30; pat_wr_bit = 1; step("R10");
        pat_wr_addr = 12'd31; step("R10");
        pat_wr_addr = 12'd3563; step("R10");
        pat_wr_addr = 12'd4000; step("R10");
        pat_wr_addr = 12'd0; step("R10");
        pat_wr_addr = 12'd0; pat_wr_bit = 0; step("R10");
        pat_wr_en = 0; bid_rst_cmd = 1; llt_req = 4'b0011; cal_req = 1; nzs_req = 1;
        step("R10");
        clear_pulses();
        for (int i = 0; i < 40; i++) step(i > 28 ? "R4" : "R10");

        // R8 / R2 / R4: two pseudo-random orbits
        for (int n = 0; n < 2 * NBX + 50; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            llt_req  = lfsr[3:0] & {4{lfsr[4]}};
            throttle = lfsr[6] & lfsr[7];
            cal_req  = (lfsr[9:8] == 2'b11) && lfsr[5];
            cal_type = lfsr[13:10];
            nzs_req  = (lfsr[15:11] == 5'd0);
            cfg_nzs_len = lfsr[3:0];
            dest     = lfsr;
            eid_rst_cmd = (lfsr[14:8] == 7'd5);
            pat_wr_en = (lfsr[15:9] == 7'd9);
            pat_wr_addr = 12'(lfsr[11:0] % 12'd3600);
            pat_wr_bit = lfsr[12];
            if (m_mask[m_bx] || m_rem > 0) step("R4");
            else if (m_bx == 0) step("R2");
            else step("R8");
        end
        clear_pulses();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog R8 got=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule